// File: doc/BRIEF.md
# Two-by-Two Systolic Multiply-Accumulate Grid

This block is a square grid of four multiply-accumulate cells that forms the product of two 2x2 matrices of signed 8-bit numbers into four signed 16-bit sums. Operands travel through the grid and the sums stay put. Each left-edge port carries one row of the first matrix, and each value shifts one cell to the right per clock. Each top-edge port carries one column of the second matrix, and each value shifts one cell down per clock. Every cell multiplies the pair of operands arriving at it and adds the product to the sum it holds.

A scheduler outside the block skews the streams. Row i receives its k-th element in cycle k+i. Column j receives its k-th element in cycle k+j. Zeros are driven in all other cycles. With this schedule the full product sits in the accumulators after the clock edge that ends cycle 3. A synchronous clear empties the accumulators between products without disturbing the operand pipeline. A rectifier select makes the outputs show only the non-negative part of each sum.

Top module: `sysmac_array`

## Requirements
- R1: `left_a0`, `left_a1`, `top_b0` and `top_b1` are two's-complement signed values of OP_W=8 bits. `c00`, `c01`, `c10` and `c11` are two's-complement signed values of ACC_W=16 bits, where `cij` is row i, column j of the result. While `relu_en` is low, each output shows its cell's accumulator unchanged.
- R2: Each cell registers the row operand it receives and passes it to the cell on its right one clock later. It also registers the column operand it receives and passes it to the cell below one clock later. `left_a0` feeds the row-0 cells, `left_a1` the row-1 cells, `top_b0` the column-0 cells and `top_b1` the column-1 cells.
- R3: An operand that leaves the right or bottom edge lands in a spill register that no cell reads. Operands streamed along rows while the column inputs are zero leave all outputs at zero.
- R4: On every clock edge without reset or clear, each cell adds the product of its two current input operands to its accumulator. The sum wraps modulo 2^16.
- R5: When `clr` is high at a clock edge, all four accumulators become zero, even if products are present that cycle. Operand forwarding continues unchanged during that cycle.
- R6: While `relu_en` is high, each output shows max(accumulator, 0). The select acts combinationally and does not change the accumulators, so lowering it shows the raw sums again.
- R7: `rst` is active high and synchronous. It zeroes all four accumulators and every forwarding and spill register.
- R8: Under the skewed schedule (row i element k in cycle k+i, column j element k in cycle k+j, zero otherwise, cycles 0 to 3), `cij` equals the sum over k of A[i][k]*B[k][j] after the edge that ends cycle 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous accumulator clear |
| relu_en | input | 1 | Shows only the non-negative part of each output when high |
| left_a0 | input | 8 | Row-0 operand entering the left edge |
| left_a1 | input | 8 | Row-1 operand entering the left edge |
| top_b0 | input | 8 | Column-0 operand entering the top edge |
| top_b1 | input | 8 | Column-1 operand entering the top edge |
| c00 | output | 16 | Result row 0, column 0 |
| c01 | output | 16 | Result row 0, column 1 |
| c10 | output | 16 | Result row 1, column 0 |
| c11 | output | 16 | Result row 1, column 1 |

## Verification
The bench sweeps a grid of extreme and small signed values, including -128, 127, -1 and 0, through the skewed schedule, and adds a batch of pseudo-random matrices. Each result is compared with the arithmetic product, first raw and then rectified. A design that multiplied unsigned, passed operands with the wrong delay or skipped the wrap would give wrong sums. A rectifier that held negative values or clobbered the accumulators would fail when the select is toggled. An all -128 product checks that 32768 wraps to -32768. A clear raised in the same cycle as the first operand pair must drop only the top-left cell's first product. A clear that blocked forwarding or lost priority would corrupt the other three cells or keep that product. Holding reset while operands are still driven, then streaming zeros, checks that the forwarding registers were really emptied.

// File: rtl/sysmac_pkg.sv
package sysmac_pkg;
    localparam int GRID_ROWS = 2;
    localparam int GRID_COLS = 2;
    localparam int DEF_OP_W  = 8;
    localparam int DEF_ACC_W = 16;
endpackage

// File: rtl/sysmac_pe.sv
module sysmac_pe #(
    parameter int OP_W  = sysmac_pkg::DEF_OP_W,
    parameter int ACC_W = sysmac_pkg::DEF_ACC_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic signed [OP_W-1:0]  a_in,
    input  logic signed [OP_W-1:0]  b_in,
    output logic signed [OP_W-1:0]  a_fwd,
    output logic signed [OP_W-1:0]  b_fwd,
    output logic signed [ACC_W-1:0] acc
);
    localparam int PROD_W = 2 * OP_W;

    typedef struct packed {
        logic signed [OP_W-1:0]  a;
        logic signed [OP_W-1:0]  b;
        logic signed [ACC_W-1:0] sum;
    } pe_state_t;

    pe_state_t st_d, st_q;
    logic signed [PROD_W-1:0] prod;

    always_comb begin
        prod   = a_in * b_in;
        st_d   = st_q;
        st_d.a = a_in;
        st_d.b = b_in;
        if (clr) begin
            st_d.sum = '0;
        end else begin
            st_d.sum = st_q.sum + ACC_W'(prod);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign a_fwd = st_q.a;
    assign b_fwd = st_q.b;
    assign acc   = st_q.sum;
endmodule

// File: rtl/sysmac_relu.sv
module sysmac_relu #(
    parameter int W = sysmac_pkg::DEF_ACC_W
) (
    input  logic                en,
    input  logic signed [W-1:0] x,
    output logic signed [W-1:0] y
);
    logic signed [W-1:0] y_d;

    always_comb begin
        y_d = x;
        if (en && x[W-1]) begin
            y_d = '0;
        end
    end

    assign y = y_d;
endmodule

// File: rtl/sysmac_array.sv
module sysmac_array #(
    parameter int OP_W  = sysmac_pkg::DEF_OP_W,
    parameter int ACC_W = sysmac_pkg::DEF_ACC_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    relu_en,
    input  logic signed [OP_W-1:0]  left_a0,
    input  logic signed [OP_W-1:0]  left_a1,
    input  logic signed [OP_W-1:0]  top_b0,
    input  logic signed [OP_W-1:0]  top_b1,
    output logic signed [ACC_W-1:0] c00,
    output logic signed [ACC_W-1:0] c01,
    output logic signed [ACC_W-1:0] c10,
    output logic signed [ACC_W-1:0] c11
);
    localparam int NR = sysmac_pkg::GRID_ROWS;
    localparam int NC = sysmac_pkg::GRID_COLS;

    // row lanes carry one extra column and column lanes one extra row:
    // the last slot is the spill register at the far edge
    logic signed [OP_W-1:0]  a_lane [NR][NC+1];
    logic signed [OP_W-1:0]  b_lane [NR+1][NC];
    logic signed [ACC_W-1:0] acc_w  [NR][NC];
    logic signed [ACC_W-1:0] out_w  [NR][NC];

    assign a_lane[0][0] = left_a0;
    assign a_lane[1][0] = left_a1;
    assign b_lane[0][0] = top_b0;
    assign b_lane[0][1] = top_b1;

    for (genvar r = 0; r < NR; r++) begin : g_row
        for (genvar c = 0; c < NC; c++) begin : g_col
            sysmac_pe #(.OP_W(OP_W), .ACC_W(ACC_W)) u_pe (
                .clk  (clk),
                .rst  (rst),
                .clr  (clr),
                .a_in (a_lane[r][c]),
                .b_in (b_lane[r][c]),
                .a_fwd(a_lane[r][c+1]),
                .b_fwd(b_lane[r+1][c]),
                .acc  (acc_w[r][c])
            );
            sysmac_relu #(.W(ACC_W)) u_relu (
                .en(relu_en),
                .x (acc_w[r][c]),
                .y (out_w[r][c])
            );
        end
    end

    assign c00 = out_w[0][0];
    assign c01 = out_w[0][1];
    assign c10 = out_w[1][0];
    assign c11 = out_w[1][1];
endmodule

// File: rtl/sysmac_array_chk.sv
module sysmac_array_chk #(
    parameter int OP_W  = sysmac_pkg::DEF_OP_W,
    parameter int ACC_W = sysmac_pkg::DEF_ACC_W
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    clr,
    input logic                    relu_en,
    input logic signed [OP_W-1:0]  left_a0,
    input logic signed [OP_W-1:0]  top_b1,
    input logic signed [OP_W-1:0]  top_b0,
    input logic signed [OP_W-1:0]  spill_a0,
    input logic signed [OP_W-1:0]  spill_b1,
    input logic signed [ACC_W-1:0] c00,
    input logic signed [ACC_W-1:0] c01,
    input logic signed [ACC_W-1:0] c10,
    input logic signed [ACC_W-1:0] c11
);
    logic [1:0] age_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            age_q <= '0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    assert_row_shift_R2: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 2'd2) |-> (spill_a0 == $past(left_a0, 2)));

    assert_col_shift_R2: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 2'd2) |-> (spill_b1 == $past(top_b1, 2)));

    assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
        clr |=> (c00 == '0 && c01 == '0 && c10 == '0 && c11 == '0));

    assert_relu_R6: assert property (@(posedge clk) disable iff (rst)
        relu_en |-> (!c00[ACC_W-1] && !c01[ACC_W-1] && !c10[ACC_W-1] && !c11[ACC_W-1]));

    assert_accum_R4: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 2'd1 && !clr && !relu_en) |=>
        (relu_en || c00 == ACC_W'($past(c00) + ACC_W'($past(left_a0) * $past(top_b0)))));
endmodule

bind sysmac_array sysmac_array_chk #(.OP_W(OP_W), .ACC_W(ACC_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr),
    .relu_en (relu_en),
    .left_a0 (left_a0),
    .top_b1  (top_b1),
    .top_b0  (top_b0),
    .spill_a0(a_lane[0][2]),
    .spill_b1(b_lane[2][1]),
    .c00     (c00),
    .c01     (c01),
    .c10     (c10),
    .c11     (c11)
);

// File: tb/tb_sysmac_array.sv
module tb_sysmac_array;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clr = 1'b0;
    logic relu_en = 1'b0;
    logic signed [7:0]  left_a0 = '0, left_a1 = '0, top_b0 = '0, top_b1 = '0;
    logic signed [15:0] c00, c01, c10, c11;

    int n_chk = 0;
    int n_fail = 0;
    int ma [2][2];
    int mb [2][2];

    always #10 clk = ~clk;

    sysmac_array dut (
        .clk(clk), .rst(rst), .clr(clr), .relu_en(relu_en),
        .left_a0(left_a0), .left_a1(left_a1), .top_b0(top_b0), .top_b1(top_b1),
        .c00(c00), .c01(c01), .c10(c10), .c11(c11)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int wrap16(input int v);
        logic signed [15:0] s;
        s = v[15:0];
        return int'(s);
    endfunction

    function automatic int relu(input int v);
        return (v < 0) ? 0 : v;
    endfunction

    task automatic zero_in();
        left_a0 = '0; left_a1 = '0; top_b0 = '0; top_b1 = '0;
    endtask

    // skewed schedule; with_clr raises clr in cycle 0 together with the first pair
    task automatic feed(input bit with_clr);
        for (int t = 0; t < 4; t++) begin
            left_a0 = (t < 2) ? 8'(ma[0][t]) : 8'sd0;
            left_a1 = (t >= 1 && t < 3) ? 8'(ma[1][t-1]) : 8'sd0;
            top_b0  = (t < 2) ? 8'(mb[t][0]) : 8'sd0;
            top_b1  = (t >= 1 && t < 3) ? 8'(mb[t-1][1]) : 8'sd0;
            clr     = with_clr && (t == 0);
            @(negedge clk);
        end
        clr = 1'b0;
        zero_in();
    endtask

    task automatic check_prod(input string tag, input bit with_clr);
        int e [2][2];
        for (int i = 0; i < 2; i++)
            for (int j = 0; j < 2; j++)
                e[i][j] = wrap16(ma[i][0]*mb[0][j] + ma[i][1]*mb[1][j]);
        if (with_clr) e[0][0] = wrap16(ma[0][1]*mb[1][0]);
        feed(with_clr);
        relu_en = 1'b0;
        #1;
        // R8 R1 R4: raw product under the skewed schedule
        chk({tag, " R8 c00"}, int'(c00), e[0][0]);
        chk({tag, " R8 c01"}, int'(c01), e[0][1]);
        chk({tag, " R8 c10"}, int'(c10), e[1][0]);
        chk({tag, " R8 c11"}, int'(c11), e[1][1]);
        relu_en = 1'b1;
        #1;
        // R6: rectified view
        chk({tag, " R6 c00"}, int'(c00), relu(e[0][0]));
        chk({tag, " R6 c01"}, int'(c01), relu(e[0][1]));
        chk({tag, " R6 c10"}, int'(c10), relu(e[1][0]));
        chk({tag, " R6 c11"}, int'(c11), relu(e[1][1]));
        relu_en = 1'b0;
        #1;
        // R6: raw value returns once the select drops
        chk({tag, " R6 restore c10"}, int'(c10), e[1][0]);
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        // R5: clear empties all accumulators
        chk({tag, " R5 cleared"}, int'(c00) | int'(c01) | int'(c10) | int'(c11), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int vals [8];
        vals = '{-128, -127, -1, 0, 1, 2, 63, 127};

        // R7: reset while operands are driven
        left_a0 = 8'sd55; left_a1 = -8'sd9; top_b0 = 8'sd77; top_b1 = 8'sd3;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        zero_in();
        #1;
        chk("R7 reset outputs", int'(c00) | int'(c01) | int'(c10) | int'(c11), 0);
        repeat (2) @(negedge clk);
        chk("R7 forwarding cleared", int'(c00) | int'(c01) | int'(c10) | int'(c11), 0);

        // R3: row streams with zero columns leave every output at zero
        for (int t = 0; t < 5; t++) begin
            left_a0 = 8'(t * 17 + 5); left_a1 = 8'(-t * 11 - 3);
            @(negedge clk);
        end
        zero_in();
        repeat (3) @(negedge clk);
        chk("R3 spill ignored", int'(c00) | int'(c01) | int'(c10) | int'(c11), 0);

        // R4: wrap, 2 * 16384 = 32768 wraps to -32768
        ma = '{'{-128, -128}, '{-128, -128}};
        mb = '{'{-128, -128}, '{-128, -128}};
        feed(1'b0);
        #1;
        chk("R4 wrap c11", int'(c11), -32768);
        @(negedge clk); clr = 1'b1; @(negedge clk); clr = 1'b0;

        // R5: clear in cycle 0 drops only the top-left first product
        ma = '{'{7, -3}, '{12, 5}};
        mb = '{'{-9, 4}, '{6, 11}};
        check_prod("clear-priority", 1'b1);

        // sweep over extreme and small values
        for (int x = 0; x < 8; x++) begin
            for (int y = 0; y < 8; y++) begin
                ma = '{'{vals[x], vals[y]}, '{vals[y], vals[x]}};
                mb = '{'{vals[y], vals[x]}, '{vals[x], vals[y]}};
                check_prod("sweep", 1'b0);
            end
        end

        // pseudo-random signed matrices
        for (int n = 0; n < 60; n++) begin
            for (int i = 0; i < 2; i++)
                for (int j = 0; j < 2; j++) begin
                    ma[i][j] = int'($signed(8'($urandom)));
                    mb[i][j] = int'($signed(8'($urandom)));
                end
            check_prod("random", 1'b0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule